// File: doc/BRIEF.md
# Interrupt Pending/Active State Controller

This block keeps the per-source state of a bank of interrupt lines (by default 64). Each source has an enable bit, a pending bit and an active bit. A source can therefore be inactive, pending, active, or active and pending. Software changes the enable and pending bits through a small word-addressed register bank. Each operation has its own address group: set enable, clear enable, set pending and clear pending. A separate read-only group shows which sources are active.

The interrupt inputs are level-sensitive and synchronous to the clock. A line that is high while its source is not active raises the pending bit. The processor reports two events by number: taking an interrupt (handler entry) and finishing it (handler return). On return, the line is looked at again, and the source becomes pending at once if the line is still high. The block presents one request: the lowest-numbered source that is enabled, pending and not active. A global mask input suppresses this request.

Top module: `intc_state_ctrl`

## Requirements
- R1: After reset every enable, pending and active bit is 0, `irq_req` is low, and reads of any register word return 0.
- R2: Enable bits are written through two groups. Set-enable lives at byte offset 0x00 and clear-enable at 0x20, with word n at +4n. Each 1 in the written data sets or clears the matching bit, and each 0 leaves that bit unchanged. Reading either group returns the current enable bits.
- R3: Pending bits work the same way, through set-pending at 0x40 and clear-pending at 0x60. A disabled source can become pending, but it raises no request.
- R4: A source whose line is high while it is not active has its pending bit set at the next clock edge.
- R5: A handler-entry strobe for source k sets active[k] and clears pending[k]. The active bits read back from the group at 0x80.
- R6: A handler-return strobe for source k clears active[k]. If line k is high at that edge, pending[k] is set at the same edge. Otherwise, with no other set, the source ends inactive.
- R7: A clear-pending write has no effect on a source whose line is high at that edge.
- R8: `irq_req` is high exactly when some source is enabled, pending and not active. `irq_id` then gives the lowest such source number.
- R9: While `irq_mask` is high, `irq_req` is low.
- R10: An access is refused with an error response, read data 0 and no state change when any of these holds: the address is not word aligned, the size code is not 2 (word), the word index is beyond the implemented sources, the group is above 0x80, or the access is a write to the active group.
- R11: Every access gets exactly one response, one cycle later (`rsp_valid`). A read returns the addressed word and a write returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_data | output | 32 | Read data |
| rsp_err | output | 1 | Access refused |
| irq_line | input | NUM_IRQ | Level-sensitive interrupt inputs |
| irq_mask | input | 1 | Global request mask |
| ent_valid | input | 1 | Processor takes interrupt `ent_id` |
| ent_id | input | ID_W | Number of the interrupt taken |
| ret_valid | input | 1 | Processor returns from interrupt `ret_id` |
| ret_id | input | ID_W | Number of the interrupt returned from |
| irq_req | output | 1 | An eligible interrupt is waiting |
| irq_id | output | ID_W | Lowest eligible interrupt number |

## Verification
The bound checker watches, on every cycle, the per-source transitions that can be checked as properties. These are: entry makes the source active; a return with the line high re-pends the source; a high line on an idle source pends it; a granted request really is eligible and unmasked; and a refused access leaves the enable bits untouched. Other behaviour only shows through the scoreboard scenarios. That covers lowest-number selection among several candidates, the read-back of set and clear groups, write-zero having no effect, clear-pending being ignored and then accepted once the line drops, and the full list of refused access kinds.

// File: rtl/intc_pkg.sv
// Shared constants for the interrupt state controller.
// Assumes an 8-bit byte address split into group [7:5], word [4:2], byte [1:0].
package intc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int WIDX_W = 3;

    typedef enum logic [2:0] {
        GRP_SETEN = 3'd0,
        GRP_CLREN = 3'd1,
        GRP_SETPD = 3'd2,
        GRP_CLRPD = 3'd3,
        GRP_ACT   = 3'd4
    } grp_e;

    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/intc_regbank.sv
// Register bank: decodes word accesses into per-source set/clear strobes and
// returns read data one cycle later. Assumes at most one access per cycle.
module intc_regbank
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_IRQ-1:0]  en_q,
    input  logic [NUM_IRQ-1:0]  pd_q,
    input  logic [NUM_IRQ-1:0]  act_q,
    output logic [NUM_IRQ-1:0]  set_en,
    output logic [NUM_IRQ-1:0]  clr_en,
    output logic [NUM_IRQ-1:0]  set_pd,
    output logic [NUM_IRQ-1:0]  clr_pd,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_err
);
    localparam int NUM_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
    localparam int PAD_W     = NUM_WORDS * DATA_W;

    logic [2:0]        grp;
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] widx_safe;
    logic              in_range;
    logic              acc_ok;
    logic              do_wr;
    logic [PAD_W-1:0]  wmask_p;
    logic [PAD_W-1:0]  rvec_p;
    logic [DATA_W-1:0] rword;

    assign grp  = addr[7:5];
    assign widx = addr[4:2];

    // Legality of the current access
    always_comb begin
        in_range  = (int'(widx) < NUM_WORDS);
        widx_safe = in_range ? widx : '0;
        acc_ok    = (addr[1:0] == 2'b00) && (size == SZ_WORD) && in_range
                 && (grp <= GRP_ACT) && !(wr && grp == GRP_ACT);
        do_wr     = sel && wr && acc_ok;
    end

    // Place the write data at the addressed word and route it to one strobe set
    always_comb begin
        wmask_p = '0;
        wmask_p[int'(widx_safe)*DATA_W +: DATA_W] = wdata;
        set_en = (do_wr && grp == GRP_SETEN) ? wmask_p[NUM_IRQ-1:0] : '0;
        clr_en = (do_wr && grp == GRP_CLREN) ? wmask_p[NUM_IRQ-1:0] : '0;
        set_pd = (do_wr && grp == GRP_SETPD) ? wmask_p[NUM_IRQ-1:0] : '0;
        clr_pd = (do_wr && grp == GRP_CLRPD) ? wmask_p[NUM_IRQ-1:0] : '0;
    end

    // Select the state vector and word a read refers to
    always_comb begin
        case (grp)
            GRP_SETEN, GRP_CLREN: rvec_p = PAD_W'(en_q);
            GRP_SETPD, GRP_CLRPD: rvec_p = PAD_W'(pd_q);
            GRP_ACT:              rvec_p = PAD_W'(act_q);
            default:              rvec_p = '0;
        endcase
        rword = rvec_p[int'(widx_safe)*DATA_W +: DATA_W];
    end

    // Register the one-cycle response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= sel;
            rsp_err   <= sel && !acc_ok;
            rsp_data  <= (sel && acc_ok && !wr) ? rword : '0;
        end
    end
endmodule

// File: rtl/intc_src_bank.sv
// Per-source enable/pending/active state. Assumes synchronous level inputs and
// entry/return numbers below NUM_IRQ. A line only pends an idle source; on
// return the line is re-sampled; clear-pending is ignored while the line is high.
module intc_src_bank #(
    parameter int NUM_IRQ = 64,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_en,
    input  logic [NUM_IRQ-1:0] clr_en,
    input  logic [NUM_IRQ-1:0] set_pd,
    input  logic [NUM_IRQ-1:0] clr_pd,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic               ent_valid,
    input  logic [ID_W-1:0]    ent_id,
    input  logic               ret_valid,
    input  logic [ID_W-1:0]    ret_id,
    output logic [NUM_IRQ-1:0] en_q,
    output logic [NUM_IRQ-1:0] pd_q,
    output logic [NUM_IRQ-1:0] act_q
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        logic ent_hit;
        logic ret_hit;
        logic pd_nxt;

        assign ent_hit = ent_valid && (int'(ent_id) == i);
        assign ret_hit = ret_valid && (int'(ret_id) == i);

        // Next pending value from entry, software and line sampling
        always_comb begin
            if (ent_hit) begin
                pd_nxt = set_pd[i];
            end else begin
                pd_nxt = (pd_q[i] && !(clr_pd[i] && !irq_line[i]))
                      || set_pd[i]
                      || (irq_line[i] && (ret_hit || !act_q[i]));
            end
        end

        // Update the three state bits of this source
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i]  <= 1'b0;
                pd_q[i]  <= 1'b0;
                act_q[i] <= 1'b0;
            end else begin
                en_q[i]  <= (en_q[i] && !clr_en[i]) || set_en[i];
                pd_q[i]  <= pd_nxt;
                act_q[i] <= ent_hit ? 1'b1 : (ret_hit ? 1'b0 : act_q[i]);
            end
        end
    end
endmodule

// File: rtl/intc_pick.sv
// Combinational selector: lowest-numbered set bit of the candidate vector.
module intc_pick #(
    parameter int NUM_IRQ = 64,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] cand,
    output logic               found,
    output logic [ID_W-1:0]    id
);
    // Scan downward so the lowest index is the last one written
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                id    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_state_ctrl.sv
// Top of the interrupt state controller: register bank, per-source state and
// lowest-number request selection. Assumes one bus access per cycle.
module intc_state_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_err,
    input  logic [NUM_IRQ-1:0]  irq_line,
    input  logic                irq_mask,
    input  logic                ent_valid,
    input  logic [ID_W-1:0]     ent_id,
    input  logic                ret_valid,
    input  logic [ID_W-1:0]     ret_id,
    output logic                irq_req,
    output logic [ID_W-1:0]     irq_id
);
    logic [NUM_IRQ-1:0] en_q, pd_q, act_q;
    logic [NUM_IRQ-1:0] set_en, clr_en, set_pd, clr_pd;
    logic [NUM_IRQ-1:0] cand;
    logic               found;

    intc_regbank #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .size(bus_size), .wdata(bus_wdata),
        .en_q(en_q), .pd_q(pd_q), .act_q(act_q),
        .set_en(set_en), .clr_en(clr_en), .set_pd(set_pd), .clr_pd(clr_pd),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    intc_src_bank #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_srcs (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .clr_en(clr_en), .set_pd(set_pd), .clr_pd(clr_pd),
        .irq_line(irq_line),
        .ent_valid(ent_valid), .ent_id(ent_id),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .en_q(en_q), .pd_q(pd_q), .act_q(act_q)
    );

    // Sources eligible to be requested
    assign cand = en_q & pd_q & ~act_q;

    intc_pick #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_pick (
        .cand(cand), .found(found), .id(irq_id)
    );

    // Global mask gates the request flag
    assign irq_req = found && !irq_mask;
endmodule

// File: rtl/intc_state_chk.sv
// Property checker for the interrupt state controller, bound to the top.
module intc_state_chk #(
    parameter int NUM_IRQ = 64,
    parameter int ID_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pd_q,
    input logic [NUM_IRQ-1:0] act_q,
    input logic [NUM_IRQ-1:0] irq_line,
    input logic               irq_mask,
    input logic               ent_valid,
    input logic [ID_W-1:0]    ent_id,
    input logic               ret_valid,
    input logic [ID_W-1:0]    ret_id,
    input logic               irq_req,
    input logic [ID_W-1:0]    irq_id,
    input logic               rsp_err
);
    // R5
    entry_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> act_q[$past(ent_id)]);

    // R6
    return_repends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && irq_line[ret_id] && !ent_valid) |=> pd_q[$past(ret_id)]);

    // R6
    return_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ent_valid) |=> !act_q[$past(ret_id)]);

    // R4
    line_pends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_line & ~act_q) && !ent_valid) |=> (($past(irq_line & ~act_q) & ~pd_q) == '0));

    // R8
    request_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_q[irq_id] && pd_q[irq_id] && !act_q[irq_id]));

    // R9
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_req);

    // R10
    refused_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (en_q == $past(en_q)));
endmodule

bind intc_state_ctrl intc_state_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .pd_q(pd_q), .act_q(act_q),
    .irq_line(irq_line), .irq_mask(irq_mask),
    .ent_valid(ent_valid), .ent_id(ent_id), .ret_valid(ret_valid), .ret_id(ret_id),
    .irq_req(irq_req), .irq_id(irq_id), .rsp_err(rsp_err)
);

// File: tb/sim_intc_state_ctrl.sv
// Scoreboard bench: bus task queues expected responses, a monitor compares them.
module sim_intc_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ    = 64;
    localparam int ID_W       = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]         bus_addr = '0;
    logic [1:0]         bus_size = 2'd2;
    logic [31:0]        bus_wdata = '0;
    logic               rsp_valid, rsp_err;
    logic [31:0]        rsp_data;
    logic [NUM_IRQ-1:0] irq_line = '0;
    logic               irq_mask = 1'b0;
    logic               ent_valid = 1'b0, ret_valid = 1'b0;
    logic [ID_W-1:0]    ent_id = '0, ret_id = '0;
    logic               irq_req;
    logic [ID_W-1:0]    irq_id;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_state_ctrl #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .irq_line(irq_line), .irq_mask(irq_mask),
        .ent_valid(ent_valid), .ent_id(ent_id), .ret_valid(ret_valid), .ret_id(ret_id),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    // Monitor: compare each response with the head of the queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11: unexpected response data=%h err=%0b, expected none", rsp_data, rsp_err);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_data !== e.data || rsp_err !== e.err) begin
                    n_fail++;
                    $display("FAIL %s: data=%h err=%0b, expected data=%h err=%0b",
                             e.tag, rsp_data, rsp_err, e.data, e.err);
                end
            end
        end
    end

    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [1:0] size,
                          input logic [31:0] wd, input logic [31:0] ed, input logic ee,
                          input string tag);
        exp_t e;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_size = size; bus_wdata = wd;
        e.data = ed; e.err = ee; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] ed, input string tag);
        bus_op(1'b0, addr, 2'd2, 32'h0, ed, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] wd, input string tag);
        bus_op(1'b1, addr, 2'd2, wd, 32'h0, 1'b0, tag);
    endtask

    task automatic chk_req(input logic er, input int eid, input string tag);
        n_chk++;
        if (irq_req !== er || (er && int'(irq_id) != eid)) begin
            n_fail++;
            $display("FAIL %s: req=%0b id=%0d, expected req=%0b id=%0d", tag, irq_req, irq_id, er, eid);
        end
    endtask

    task automatic take(input int id);
        @(negedge clk);
        ent_valid = 1'b1; ent_id = ID_W'(id);
        @(negedge clk);
        ent_valid = 1'b0;
    endtask

    task automatic give_back(input int id);
        @(negedge clk);
        ret_valid = 1'b1; ret_id = ID_W'(id);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_req(1'b0, 0, "R1 reset request");
        rd(8'h00, 32'h0, "R1 enable word0");
        rd(8'h44, 32'h0, "R1 pending word1");
        rd(8'h84, 32'h0, "R1 active word1");

        // R2: set, clear, write-zero, read-back through both groups
        wr(8'h00, 32'h0000_0030, "R2 set enable");
        rd(8'h20, 32'h0000_0030, "R2 read via clear group");
        wr(8'h20, 32'h0000_0010, "R2 clear enable");
        wr(8'h00, 32'h0000_0000, "R2 write zero");
        rd(8'h00, 32'h0000_0020, "R2 enable after clear and zero write");

        // R3: pend a disabled source, then enable it
        wr(8'h44, 32'h0000_0008, "R3 set pending 35");
        chk_req(1'b0, 0, "R3 disabled pending no request");
        rd(8'h64, 32'h0000_0008, "R3 pending read via clear group");
        wr(8'h04, 32'h0000_0008, "R3 enable 35");
        chk_req(1'b1, 35, "R8 request 35");

        // R8: lower number wins
        wr(8'h40, 32'h0000_0020, "R8 set pending 5");
        chk_req(1'b1, 5, "R8 lowest number 5");

        // R9: mask
        @(negedge clk); irq_mask = 1'b1;
        #1 chk_req(1'b0, 0, "R9 masked");
        @(negedge clk); irq_mask = 1'b0;
        #1 chk_req(1'b1, 5, "R9 unmasked");

        // R5: entry
        take(5);
        rd(8'h80, 32'h0000_0020, "R5 active word0");
        rd(8'h40, 32'h0000_0000, "R5 pending cleared on entry");
        chk_req(1'b1, 35, "R8 active source skipped");

        // R6: return with line high re-pends
        @(negedge clk); irq_line[5] = 1'b1;
        give_back(5);
        rd(8'h40, 32'h0000_0020, "R6 re-pended on return");
        rd(8'h80, 32'h0000_0000, "R6 active cleared");
        chk_req(1'b1, 5, "R6 request again");

        // R7: clear ignored while line high, accepted after it drops
        wr(8'h60, 32'h0000_0020, "R7 clear with line high");
        rd(8'h40, 32'h0000_0020, "R7 still pending");
        @(negedge clk); irq_line[5] = 1'b0;
        wr(8'h60, 32'h0000_0020, "R7 clear with line low");
        rd(8'h40, 32'h0000_0000, "R7 pending cleared");

        // R6: return with line low ends inactive
        take(35);
        give_back(35);
        rd(8'h84, 32'h0000_0000, "R6 active word1 after return");
        rd(8'h44, 32'h0000_0000, "R6 inactive after return");
        chk_req(1'b0, 0, "R6 no request");

        // R4: line pends an idle disabled source
        @(negedge clk); irq_line[40] = 1'b1;
        @(negedge clk);
        rd(8'h44, 32'h0000_0100, "R4 line pends 40");
        chk_req(1'b0, 0, "R4 disabled no request");

        // R10: refused accesses
        bus_op(1'b1, 8'h01, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10 misaligned write");
        bus_op(1'b1, 8'h00, 2'd1, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10 half-word write");
        bus_op(1'b0, 8'h08, 2'd2, 32'h0,         32'h0, 1'b1, "R10 word out of range");
        bus_op(1'b0, 8'hA0, 2'd2, 32'h0,         32'h0, 1'b1, "R10 group out of map");
        bus_op(1'b1, 8'h80, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10 write to active");
        rd(8'h00, 32'h0000_0020, "R10 enable word0 unchanged");
        rd(8'h80, 32'h0000_0000, "R10 active unchanged");

        @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d responses missing, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule